// File: doc/BRIEF.md
# Decoder Soft-Reset and Status Controller

This block holds the command register, the control and counter registers, and the status register of a bitstream decoder engine. It also gates the requests of that engine's DMA masters. A CPU write port issues commands. One command code asks for a soft reset of the engine. On a soft reset, any DMA burst that is already running is allowed to finish, and no new burst is granted. When nothing is in flight, the block raises a one-cycle ready-to-reset flag together with a clear strobe for the engine's own state machines. It then returns its registers to their reset values.

Each DMA master is seen as a request line, which the block turns into a grant, and a busy line, which the master holds high for the length of a burst. The status register collects event flags. Software clears those flags by writing 1 to them. The exception is the command-done flag, which only a new command can clear. A level interrupt is driven from the enabled status flags and from the ready-to-reset flag.

Top module: `dec_reset_ctrl`

## Requirements
- R1: A CPU write of the code 0x7 to the command register (word address 0) starts a soft reset. A write of any other code to that address is an ordinary command, and it is stored in the command register.
- R2: A burst already in flight is never cut short. A burst is in flight when its dma_busy bit is high, or when it was granted in the same cycle as the reset command. ready_to_reset stays low until every dma_busy bit has been seen low.
- R3: From the cycle after the reset command is accepted until the reset completes, dma_grant stays 0 whatever dma_req does. At all other times dma_grant equals dma_req.
- R4: ready_to_reset is high for exactly one cycle. In that cycle engine_clear and irq are also high.
- R5: If no DMA is in flight when the reset command is accepted, ready_to_reset goes high in the very next cycle.
- R6: After the reset completes, these registers read 0: command (0), control (2), bit count (4), input count (5), header count (6) and run-level count (7). The interrupt-enable register (3) keeps its value.
- R7: After a soft reset, and after the hardware reset, the status register (address 1) reads 0x1.
- R8: Writing 1 to status bit n (n ≥ 1) clears that bit, and writing 0 leaves it unchanged. If an event sets a bit in the same cycle as a write clears it, the bit stays set.
- R9: Status bit 0 (command done) is set by a cmd_done_in pulse. It is cleared only by a command write. A CPU write of 1 to bit 0 is ignored.
- R10: Each cnt_step pulse steps one count register by one. Index 0 steps bit count up, index 2 steps header count up and index 3 steps run-level count up. Index 1 steps input count down and stops at 0. A step that takes the input count from 1 to 0 sets status bit 1 (input done).
- R11: When the soft reset clears the input count, status bit 1 is not set and no interrupt is raised for it.
- R12: A pulse on stat_evt[k] sets status bit k+2. Several status bits can be set at the same time.
- R13: irq is high while any status bit whose matching interrupt-enable bit is set is high, or while ready_to_reset is high. irq falls once software clears those status bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| cpu_we | input | 1 | CPU register write strobe |
| cpu_waddr | input | AW | CPU write word address |
| cpu_wdata | input | DW | CPU write data |
| cpu_raddr | input | AW | CPU read word address |
| cpu_rdata | output | DW | CPU read data, combinational from the registers |
| dma_req | input | N_DMA | Burst request, one bit per DMA master |
| dma_busy | input | N_DMA | Burst in progress, one bit per DMA master |
| dma_grant | output | N_DMA | Burst grant, one bit per DMA master |
| cmd_done_in | input | 1 | Engine reports that the current command has finished |
| cnt_step | input | 4 | Step pulses for the four count registers |
| stat_evt | input | N_EVT | Event pulses that set status bits 2 and up |
| ready_to_reset | output | 1 | DMA has drained and the soft reset is being applied |
| engine_clear | output | 1 | Clear strobe for the engine's internal state machines |
| irq | output | 1 | Level interrupt to the CPU |

## Verification
The soft reset is tried with three DMA patterns. With no burst active, the flag must come one cycle after the command. With a burst already running, the bench checks that the block waits for dma_busy to fall and keeps every request refused meanwhile. With a grant issued in the same cycle as the command, the bench checks that a burst which has only just started still holds off the reset. The status register is given writes of 0, targeted writes of 1, a write of 1 to bit 0, and a clear that coincides with a set event. These patterns separate real write-1-to-clear behaviour from overwrite, and separate a sticky command-done bit from an ordinary flag. Loading the input count before the reset shows whether clearing it is confused with counting it down.

// File: rtl/dec_rst_pkg.sv
package dec_rst_pkg;

   typedef enum logic [1:0] {
      RS_IDLE  = 2'd0,
      RS_DRAIN = 2'd1,
      RS_READY = 2'd2
   } rst_state_e;

   // count registers
   localparam int NUM_CNT   = 4;
   localparam int CNT_BITS  = 0;
   localparam int CNT_INPUT = 1;
   localparam int CNT_HDR   = 2;
   localparam int CNT_RL    = 3;
   localparam logic [NUM_CNT-1:0] CNT_DOWN_MASK = 4'b0010;

   // register word addresses
   localparam int unsigned A_CMD  = 0;
   localparam int unsigned A_STAT = 1;
   localparam int unsigned A_CTRL = 2;
   localparam int unsigned A_IEN  = 3;
   localparam int unsigned A_CNT0 = 4;
   localparam int unsigned NUM_REGS = A_CNT0 + NUM_CNT;

   // status bit positions
   localparam int ST_CMD_DONE = 0;
   localparam int ST_IN_DONE  = 1;
   localparam int ST_EVT0     = 2;

endpackage

// File: rtl/dec_cnt_reg.sv
module dec_cnt_reg #(
   parameter int W    = 16,
   parameter bit DOWN = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         ld,
   input  logic [W-1:0] ld_val,
   input  logic         step,
   output logic [W-1:0] q,
   output logic         reach_zero
);

   logic [W-1:0] q_step;

   generate
      if (DOWN) begin : g_down
         always_comb begin
            q_step     = (q != '0) ? q - W'(1) : q;
            reach_zero = step && !ld && !clr && (q == W'(1));
         end

         assert_count_down_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (step && !ld && !clr && q != '0) |=> (q == $past(q) - W'(1)));
      end else begin : g_up
         always_comb begin
            q_step     = q + W'(1);
            reach_zero = 1'b0;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else if (clr) begin
         q <= '0;
      end else if (ld) begin
         q <= ld_val;
      end else if (step) begin
         q <= q_step;
      end
   end

   assert_clear_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (q == '0));

endmodule

// File: rtl/dec_dma_gate.sv
module dec_dma_gate #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         block,
   input  logic [N-1:0] req,
   input  logic [N-1:0] busy,
   output logic [N-1:0] grant,
   output logic         active
);

   logic [N-1:0] started_q;
   logic [N-1:0] inflight;

   generate
      for (genvar i = 0; i < N; i++) begin : g_ch
         assign grant[i] = req[i] & ~block;

         // covers the gap between grant and the master raising busy
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) started_q[i] <= 1'b0;
            else        started_q[i] <= grant[i];
         end

         assign inflight[i] = busy[i] | started_q[i];
      end
   endgenerate

   // a grant issued this cycle counts as a burst already started
   assign active = (|inflight) | (|grant);

endmodule

// File: rtl/dec_rst_fsm.sv
module dec_rst_fsm
   import dec_rst_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rst_cmd,
   input  logic       dma_active,
   output rst_state_e state,
   output logic       block,
   output logic       ready,
   output logic       soft_clr
);

   rst_state_e state_nx;

   always_comb begin
      state_nx = state;
      unique case (state)
         RS_IDLE:  if (rst_cmd) state_nx = dma_active ? RS_DRAIN : RS_READY;
         RS_DRAIN: if (!dma_active) state_nx = RS_READY;
         RS_READY: state_nx = RS_IDLE;
         default:  state_nx = RS_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= RS_IDLE;
      else        state <= state_nx;
   end

   assign block    = (state != RS_IDLE);
   assign ready    = (state == RS_READY);
   assign soft_clr = ready;

   assert_ready_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ready |=> !ready);

   assert_wait_drain_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == RS_DRAIN && dma_active) |=> !ready);

   assert_fast_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == RS_IDLE && rst_cmd && !dma_active) |=> ready);

endmodule

// File: rtl/dec_status_reg.sv
module dec_status_reg
   import dec_rst_pkg::*;
#(
   parameter int N_EVT = 4,
   localparam int W    = ST_EVT0 + N_EVT
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             cmd_issue,
   input  logic             done_set,
   input  logic             in_done_set,
   input  logic [N_EVT-1:0] evt,
   input  logic             w1c_we,
   input  logic [W-1:0]     w1c_data,
   output logic [W-1:0]     q
);

   logic [W-1:0] set_vec;
   logic [W-1:0] clr_mask;
   logic [W-1:0] q_nx;

   always_comb begin
      set_vec              = '0;
      set_vec[ST_IN_DONE]  = in_done_set;
      set_vec[W-1:ST_EVT0] = evt;

      clr_mask              = w1c_we ? w1c_data : '0;
      clr_mask[ST_CMD_DONE] = 1'b0;

      if (clr) begin
         q_nx = W'(1);
      end else begin
         q_nx = (q & ~clr_mask) | set_vec;
         if (cmd_issue)     q_nx[ST_CMD_DONE] = 1'b0;
         else if (done_set) q_nx[ST_CMD_DONE] = 1'b1;
         else               q_nx[ST_CMD_DONE] = q[ST_CMD_DONE];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= W'(1);
      else        q <= q_nx;
   end

   assert_after_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (q == W'(1)));

   assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !cmd_issue && q[ST_CMD_DONE]) |=> q[ST_CMD_DONE]);

   assert_no_in_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !q[ST_IN_DONE]);

   assert_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (w1c_we && !clr) |=>
         ((q[W-1:1] & $past(w1c_data[W-1:1] & ~set_vec[W-1:1])) == '0));

   assert_evt_set_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && evt != '0) |=> ((q[W-1:ST_EVT0] & $past(evt)) == $past(evt)));

endmodule

// File: rtl/dec_reset_ctrl.sv
module dec_reset_ctrl
   import dec_rst_pkg::*;
#(
   parameter int              DW       = 32,
   parameter int              AW       = 3,
   parameter int              N_DMA    = 2,
   parameter int              N_EVT    = 4,
   parameter int              CNT_W    = 16,
   parameter int              CTRL_W   = 32,
   parameter int              CMD_W    = 4,
   parameter logic [CMD_W-1:0] RST_CODE = 4'h7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cpu_we,
   input  logic [AW-1:0]    cpu_waddr,
   input  logic [DW-1:0]    cpu_wdata,
   input  logic [AW-1:0]    cpu_raddr,
   output logic [DW-1:0]    cpu_rdata,
   input  logic [N_DMA-1:0] dma_req,
   input  logic [N_DMA-1:0] dma_busy,
   output logic [N_DMA-1:0] dma_grant,
   input  logic             cmd_done_in,
   input  logic [3:0]       cnt_step,
   input  logic [N_EVT-1:0] stat_evt,
   output logic             ready_to_reset,
   output logic             engine_clear,
   output logic             irq
);

   localparam int STAT_W = ST_EVT0 + N_EVT;

   // elaboration-time parameter checks
   generate
      if (N_DMA < 1) begin : g_err_dma
         $error("dec_reset_ctrl: N_DMA must be at least 1");
      end
      if ((1 << AW) < NUM_REGS) begin : g_err_aw
         $error("dec_reset_ctrl: AW too small for the register map");
      end
      if (STAT_W > DW || CNT_W > DW || CTRL_W > DW || CMD_W > DW) begin : g_err_dw
         $error("dec_reset_ctrl: a register is wider than DW");
      end
      if (N_EVT < 1) begin : g_err_evt
         $error("dec_reset_ctrl: N_EVT must be at least 1");
      end
   endgenerate

   rst_state_e         fsm_state;
   logic               gate_block;
   logic               dma_active;
   logic               soft_clr;
   logic               fsm_ready;

   logic               wr_cmd, wr_stat, wr_ctrl, wr_ien;
   logic               cmd_accept, rst_cmd, cmd_issue;
   logic [CMD_W-1:0]   cmd_q;
   logic [CTRL_W-1:0]  ctrl_q;
   logic [STAT_W-1:0]  ien_q;
   logic [STAT_W-1:0]  stat_q;
   logic [CNT_W-1:0]   cnt_q   [NUM_CNT];
   logic [NUM_CNT-1:0] cnt_zero;
   logic [NUM_CNT-1:0] cnt_ld;

   // ---------------- write decode ----------------
   assign wr_cmd  = cpu_we && (cpu_waddr == AW'(A_CMD));
   assign wr_stat = cpu_we && (cpu_waddr == AW'(A_STAT));
   assign wr_ctrl = cpu_we && (cpu_waddr == AW'(A_CTRL));
   assign wr_ien  = cpu_we && (cpu_waddr == AW'(A_IEN));

   // commands only take effect while no reset is underway
   assign cmd_accept = wr_cmd && (fsm_state == RS_IDLE);
   assign rst_cmd    = cmd_accept && (cpu_wdata[CMD_W-1:0] == RST_CODE);
   assign cmd_issue  = cmd_accept;

   // ---------------- DMA gating ----------------
   dec_dma_gate #(.N(N_DMA)) u_gate (
      .clk    (clk),
      .rst_n  (rst_n),
      .block  (gate_block),
      .req    (dma_req),
      .busy   (dma_busy),
      .grant  (dma_grant),
      .active (dma_active)
   );

   // ---------------- reset sequencer ----------------
   dec_rst_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .rst_cmd    (rst_cmd),
      .dma_active (dma_active),
      .state      (fsm_state),
      .block      (gate_block),
      .ready      (fsm_ready),
      .soft_clr   (soft_clr)
   );

   assign ready_to_reset = fsm_ready;
   assign engine_clear   = soft_clr;

   // ---------------- plain registers ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q  <= '0;
         ctrl_q <= '0;
      end else if (soft_clr) begin
         cmd_q  <= '0;
         ctrl_q <= '0;
      end else begin
         if (cmd_accept) cmd_q  <= cpu_wdata[CMD_W-1:0];
         if (wr_ctrl)    ctrl_q <= cpu_wdata[CTRL_W-1:0];
      end
   end

   // interrupt enable survives soft reset
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ien_q <= '0;
      else if (wr_ien) ien_q <= cpu_wdata[STAT_W-1:0];
   end

   // ---------------- count registers ----------------
   generate
      for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
         assign cnt_ld[i] = cpu_we && (cpu_waddr == AW'(A_CNT0 + i));

         dec_cnt_reg #(
            .W    (CNT_W),
            .DOWN (CNT_DOWN_MASK[i])
         ) u_cnt (
            .clk        (clk),
            .rst_n      (rst_n),
            .clr        (soft_clr),
            .ld         (cnt_ld[i]),
            .ld_val     (cpu_wdata[CNT_W-1:0]),
            .step       (cnt_step[i]),
            .q          (cnt_q[i]),
            .reach_zero (cnt_zero[i])
         );
      end
   endgenerate

   // ---------------- status ----------------
   dec_status_reg #(.N_EVT(N_EVT)) u_stat (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr         (soft_clr),
      .cmd_issue   (cmd_issue),
      .done_set    (cmd_done_in),
      .in_done_set (cnt_zero[CNT_INPUT]),
      .evt         (stat_evt),
      .w1c_we      (wr_stat),
      .w1c_data    (cpu_wdata[STAT_W-1:0]),
      .q           (stat_q)
   );

   assign irq = (|(stat_q & ien_q)) | fsm_ready;

   // ---------------- read mux ----------------
   always_comb begin
      cpu_rdata = '0;
      if (cpu_raddr == AW'(A_CMD))  cpu_rdata[CMD_W-1:0]  = cmd_q;
      if (cpu_raddr == AW'(A_STAT)) cpu_rdata[STAT_W-1:0] = stat_q;
      if (cpu_raddr == AW'(A_CTRL)) cpu_rdata[CTRL_W-1:0] = ctrl_q;
      if (cpu_raddr == AW'(A_IEN))  cpu_rdata[STAT_W-1:0] = ien_q;
      for (int i = 0; i < NUM_CNT; i++) begin
         if (cpu_raddr == AW'(A_CNT0 + i)) cpu_rdata[CNT_W-1:0] = cnt_q[i];
      end
   end

   // ---------------- assertions ----------------
   assert_irq_on_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ready_to_reset |-> (irq && engine_clear));

   assert_no_grant_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ready_to_reset |-> (dma_grant == '0));

   assert_cmd_refused_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rst_cmd |=> (dma_grant == '0));

   assert_regs_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      soft_clr |=> (cmd_q == '0 && ctrl_q == '0));

endmodule

// File: tb/dec_reset_ctrl_bench.sv
module dec_reset_ctrl_bench;

   localparam int AW    = 3;
   localparam int DW    = 32;
   localparam int N_DMA = 2;
   localparam int N_EVT = 4;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cpu_we = 1'b0;
   logic [AW-1:0]    cpu_waddr = '0;
   logic [DW-1:0]    cpu_wdata = '0;
   logic [AW-1:0]    cpu_raddr = '0;
   logic [DW-1:0]    cpu_rdata;
   logic [N_DMA-1:0] dma_req = '0;
   logic [N_DMA-1:0] dma_busy = '0;
   logic [N_DMA-1:0] dma_grant;
   logic             cmd_done_in = 1'b0;
   logic [3:0]       cnt_step = '0;
   logic [N_EVT-1:0] stat_evt = '0;
   logic             ready_to_reset;
   logic             engine_clear;
   logic             irq;

   int  n_chk  = 0;
   int  n_fail = 0;
   bit  done   = 1'b0;

   always #2.5 clk = ~clk;

   dec_reset_ctrl u_dec_reset_ctrl (
      .clk            (clk),
      .rst_n          (rst_n),
      .cpu_we         (cpu_we),
      .cpu_waddr      (cpu_waddr),
      .cpu_wdata      (cpu_wdata),
      .cpu_raddr      (cpu_raddr),
      .cpu_rdata      (cpu_rdata),
      .dma_req        (dma_req),
      .dma_busy       (dma_busy),
      .dma_grant      (dma_grant),
      .cmd_done_in    (cmd_done_in),
      .cnt_step       (cnt_step),
      .stat_evt       (stat_evt),
      .ready_to_reset (ready_to_reset),
      .engine_clear   (engine_clear),
      .irq            (irq)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic rdchk(input string tag, input int addr, input logic [31:0] exp);
      cpu_raddr = AW'(addr);
      #1;
      chk(tag, cpu_rdata, exp);
   endtask

   task automatic wr(input int addr, input logic [31:0] data);
      @(negedge clk);
      cpu_we    = 1'b1;
      cpu_waddr = AW'(addr);
      cpu_wdata = data;
      @(negedge clk);
      cpu_we    = 1'b0;
   endtask

   task automatic pulse_step(input int idx);
      @(negedge clk);
      cnt_step[idx] = 1'b1;
      @(negedge clk);
      cnt_step = '0;
   endtask

   task automatic pulse_evt(input logic [N_EVT-1:0] v);
      @(negedge clk);
      stat_evt = v;
      @(negedge clk);
      stat_evt = '0;
   endtask

   task automatic t_reset_state();
      rdchk("R7 status after hw reset", 1, 32'h1);
      chk("R4 ready low after reset", 32'(ready_to_reset), 0);
      chk("R13 irq low after reset", 32'(irq), 0);
      dma_req = 2'b01;
      #1;
      chk("R3 grant follows req when idle", 32'(dma_grant), 32'h1);
      dma_req = '0;
   endtask

   task automatic t_idle_reset();
      wr(2, 32'h5); wr(4, 32'h9); wr(5, 32'h3); wr(6, 32'h4); wr(7, 32'h2);
      wr(3, 32'h4);
      pulse_evt(4'b0001);
      rdchk("R12 event sets bit 2", 1, 32'h5);
      wr(0, 32'h7);
      chk("R5 ready next cycle", 32'(ready_to_reset), 1);
      chk("R4 engine_clear with ready", 32'(engine_clear), 1);
      chk("R4 irq with ready", 32'(irq), 1);
      @(negedge clk);
      chk("R4 ready one cycle", 32'(ready_to_reset), 0);
      rdchk("R6 command cleared", 0, 0);
      rdchk("R6 control cleared", 2, 0);
      rdchk("R6 bit count cleared", 4, 0);
      rdchk("R6 input count cleared", 5, 0);
      rdchk("R6 header count cleared", 6, 0);
      rdchk("R6 run-level count cleared", 7, 0);
      rdchk("R6 irq enable kept", 3, 32'h4);
      rdchk("R7 R11 status 0x1 after soft reset", 1, 32'h1);
      chk("R11 no irq after clear", 32'(irq), 0);
   endtask

   task automatic t_drain();
      @(negedge clk);
      dma_busy = 2'b01;
      wr(0, 32'h7);
      chk("R2 ready waits for busy", 32'(ready_to_reset), 0);
      dma_req = 2'b11;
      #1;
      chk("R3 grant refused during drain", 32'(dma_grant), 0);
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk("R2 still draining", 32'(ready_to_reset), 0);
         chk("R3 grant still refused", 32'(dma_grant), 0);
      end
      dma_busy = '0;
      @(negedge clk);
      chk("R2 ready after drain", 32'(ready_to_reset), 1);
      chk("R3 grant refused at ready", 32'(dma_grant), 0);
      @(negedge clk);
      #1;
      chk("R3 grant restored after reset", 32'(dma_grant), 32'h3);
      dma_req = '0;
   endtask

   task automatic t_same_cycle_grant();
      @(negedge clk);
      dma_req   = 2'b10;
      cpu_we    = 1'b1;
      cpu_waddr = AW'(0);
      cpu_wdata = 32'h7;
      #1;
      chk("R3 grant in command cycle", 32'(dma_grant), 32'h2);
      @(negedge clk);
      cpu_we   = 1'b0;
      dma_req  = '0;
      dma_busy = 2'b10;
      chk("R2 fresh burst holds reset", 32'(ready_to_reset), 0);
      @(negedge clk);
      chk("R2 fresh burst still held", 32'(ready_to_reset), 0);
      dma_busy = '0;
      @(negedge clk);
      chk("R2 ready after fresh burst", 32'(ready_to_reset), 1);
      @(negedge clk);
   endtask

   task automatic t_w1c();
      wr(3, 32'h3C);
      pulse_evt(4'b0101);
      rdchk("R12 two bits set together", 1, 32'h15);
      chk("R13 irq on enabled bit", 32'(irq), 1);
      wr(1, 32'h0);
      rdchk("R8 write 0 no effect", 1, 32'h15);
      wr(1, 32'h4);
      rdchk("R8 write 1 clears bit 2", 1, 32'h11);
      chk("R13 irq held by bit 4", 32'(irq), 1);
      wr(1, 32'h10);
      rdchk("R8 write 1 clears bit 4", 1, 32'h01);
      chk("R13 irq falls after clear", 32'(irq), 0);
      @(negedge clk);
      stat_evt  = 4'b0001;
      cpu_we    = 1'b1;
      cpu_waddr = AW'(1);
      cpu_wdata = 32'h4;
      @(negedge clk);
      stat_evt = '0;
      cpu_we   = 1'b0;
      rdchk("R8 set wins over clear", 1, 32'h05);
      wr(1, 32'h4);
   endtask

   task automatic t_cmd_done();
      wr(1, 32'h1);
      rdchk("R9 write 1 to bit 0 ignored", 1, 32'h1);
      wr(0, 32'h3);
      rdchk("R9 new command clears bit 0", 1, 32'h0);
      rdchk("R1 ordinary command stored", 0, 32'h3);
      chk("R1 ordinary command no reset", 32'(ready_to_reset), 0);
      wr(1, 32'h1);
      rdchk("R9 bit 0 not set by write", 1, 32'h0);
      @(negedge clk);
      cmd_done_in = 1'b1;
      @(negedge clk);
      cmd_done_in = 1'b0;
      rdchk("R9 cmd_done_in sets bit 0", 1, 32'h1);
   endtask

   task automatic t_counters();
      wr(5, 32'h2);
      pulse_step(1);
      rdchk("R10 input count down", 5, 32'h1);
      rdchk("R10 no input done yet", 1, 32'h1);
      pulse_step(1);
      rdchk("R10 input count zero", 5, 32'h0);
      rdchk("R10 input done set", 1, 32'h3);
      pulse_step(1);
      rdchk("R10 input count stops at 0", 5, 32'h0);
      wr(1, 32'h2);
      rdchk("R8 input done cleared", 1, 32'h1);
      wr(4, 32'h0);
      pulse_step(0);
      pulse_step(0);
      rdchk("R10 bit count up", 4, 32'h2);
      pulse_step(2);
      rdchk("R10 header count up", 6, 32'h1);
      pulse_step(3);
      rdchk("R10 run-level count up", 7, 32'h1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset_state();
      t_idle_reset();
      t_drain();
      t_same_cycle_grant();
      t_w1c();
      t_cmd_done();
      t_counters();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL R1 watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule